// File: doc/BRIEF.md
# Two-Window Segment Address Translator

This block turns a short logical address into a full physical memory address by way of two 5-bit segment selectors. Memory is treated as 32 segments of 1024 words each. The low half of the 2K logical space is the code window and the high half is the operand window. Each window is placed on a segment of its own choosing, so two segments that can sit anywhere in memory appear to a program as one contiguous 2K range.

The block holds the two selector registers: the code segment register and the operand segment register. Each has its own write strobe and data input, and each has a read output that is always visible. The caller tags every access as an instruction fetch, a direct operand reference or an indirect operand reference. The operand window holds no directly addressable words. A direct reference into that window therefore raises a combinational error flag. When this happens, the physical address is still formed from the operand segment.

Top module: `seg_xlate`

## Requirements
- R1: After reset both selector registers read 0, so the physical address equals the low 10 logical bits.
- R2: When `cseg_we` is high at a rising clock edge, `cseg_q` takes `cseg_wdata` after that edge, and `oseg_q` keeps its value.
- R3: When `oseg_we` is high at a rising clock edge, `oseg_q` takes `oseg_wdata` after that edge, and `cseg_q` keeps its value.
- R4: When logical bit 10 is 0, `paddr` equals `{cseg_q, laddr[9:0]}`, i.e. code segment × 1024 + offset.
- R5: When logical bit 10 is 1, `paddr` equals `{oseg_q, laddr[9:0]}`.
- R6: With access kind 2'b01 (direct operand) and logical bit 10 set, `ref_err` is 1 in the same cycle, and `paddr` is still formed from `oseg_q`.
- R7: `ref_err` is 0 for kind 2'b00 (fetch), 2'b10 (indirect) and 2'b11 (reserved), and for any kind when logical bit 10 is 0.
- R8: The two selectors are independent. They may be equal, adjacent, in either order or in different 4K banks, and each window still maps onto its own segment.
- R9: A change on `cseg_wdata` or `oseg_wdata` while its strobe is low leaves both selectors and `paddr` unchanged.
- R10: A translation made in the same cycle as a selector write uses the old selector value. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| laddr | input | 11 | Logical address; bit 10 selects the window |
| acc_kind | input | 2 | 00 fetch, 01 direct operand, 10 indirect operand, 11 reserved |
| cseg_we | input | 1 | Write strobe for the code segment register |
| cseg_wdata | input | 5 | New code segment value |
| oseg_we | input | 1 | Write strobe for the operand segment register |
| oseg_wdata | input | 5 | New operand segment value |
| cseg_q | output | 5 | Current code segment |
| oseg_q | output | 5 | Current operand segment |
| paddr | output | 15 | Physical address |
| ref_err | output | 1 | Direct reference into the operand window |

## Verification
The hardest case to reach from the ports is a selector write and a translation in the same cycle, where the result must use the segment that held before the edge. The bench sets the strobe together with an address aimed at the window being rewritten. It samples `paddr` after the inputs settle but before the edge, then samples again after the edge. It also drives both selectors to the same value and then to opposite extremes. This shows that only logical bit 10, and never the relation between the two selector values, decides which segment is used.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH    = 2'b00,
    ACC_DIRECT   = 2'b01,
    ACC_INDIRECT = 2'b10,
    ACC_RSVD     = 2'b11
  } acc_kind_e;

  localparam int unsigned NUM_WIN = 2;
  localparam int unsigned WIN_CODE = 0;
  localparam int unsigned WIN_OPER = 1;
endpackage

// File: rtl/segx_sel_reg.sv
module segx_sel_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/segx_window_mux.sv
module segx_window_mux #(
  parameter int unsigned SEG_BITS = 5,
  parameter int unsigned OFS_BITS = 10,
  localparam int unsigned LA_W = OFS_BITS + 1,
  localparam int unsigned PA_W = SEG_BITS + OFS_BITS
) (
  input  logic [SEG_BITS-1:0] code_seg,
  input  logic [SEG_BITS-1:0] oper_seg,
  input  logic [LA_W-1:0]     laddr,
  output logic                win_oper,
  output logic [PA_W-1:0]     paddr
);
  function automatic logic [PA_W-1:0] phys_of(
    input logic [SEG_BITS-1:0] seg,
    input logic [OFS_BITS-1:0] ofs
  );
    return {seg, ofs};
  endfunction

  assign win_oper = laddr[LA_W-1];
  assign paddr = phys_of(win_oper ? oper_seg : code_seg, laddr[OFS_BITS-1:0]);
endmodule

// File: rtl/segx_ref_check.sv
module segx_ref_check
  import segx_pkg::*;
(
  input  logic [1:0] acc_kind,
  input  logic       win_oper,
  output logic       ref_err
);
  function automatic logic illegal_ref(input acc_kind_e k, input logic oper);
    return (k == ACC_DIRECT) && oper;
  endfunction

  assign ref_err = illegal_ref(acc_kind_e'(acc_kind), win_oper);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import segx_pkg::*;
#(
  parameter int unsigned SEG_BITS = 5,
  parameter int unsigned OFS_BITS = 10,
  localparam int unsigned LA_W = OFS_BITS + 1,
  localparam int unsigned PA_W = SEG_BITS + OFS_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LA_W-1:0]     laddr,
  input  logic [1:0]          acc_kind,
  input  logic                cseg_we,
  input  logic [SEG_BITS-1:0] cseg_wdata,
  input  logic                oseg_we,
  input  logic [SEG_BITS-1:0] oseg_wdata,
  output logic [SEG_BITS-1:0] cseg_q,
  output logic [SEG_BITS-1:0] oseg_q,
  output logic [PA_W-1:0]     paddr,
  output logic                ref_err
);
  logic                we_v   [NUM_WIN];
  logic [SEG_BITS-1:0] wd_v   [NUM_WIN];
  logic [SEG_BITS-1:0] seg_v  [NUM_WIN];
  logic                win_oper;

  assign we_v[WIN_CODE] = cseg_we;
  assign wd_v[WIN_CODE] = cseg_wdata;
  assign we_v[WIN_OPER] = oseg_we;
  assign wd_v[WIN_OPER] = oseg_wdata;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_sel
    segx_sel_reg #(.W(SEG_BITS)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_v[g]),
      .wdata (wd_v[g]),
      .q     (seg_v[g])
    );
  end

  assign cseg_q = seg_v[WIN_CODE];
  assign oseg_q = seg_v[WIN_OPER];

  segx_window_mux #(.SEG_BITS(SEG_BITS), .OFS_BITS(OFS_BITS)) u_mux (
    .code_seg (seg_v[WIN_CODE]),
    .oper_seg (seg_v[WIN_OPER]),
    .laddr    (laddr),
    .win_oper (win_oper),
    .paddr    (paddr)
  );

  segx_ref_check u_chk_ref (
    .acc_kind (acc_kind),
    .win_oper (win_oper),
    .ref_err  (ref_err)
  );
endmodule

// File: rtl/segx_checker.sv
module segx_checker #(
  parameter int unsigned SEG_BITS = 5,
  parameter int unsigned OFS_BITS = 10,
  localparam int unsigned LA_W = OFS_BITS + 1,
  localparam int unsigned PA_W = SEG_BITS + OFS_BITS
) (
  input logic                clk,
  input logic                rst_n,
  input logic [LA_W-1:0]     laddr,
  input logic [1:0]          acc_kind,
  input logic                cseg_we,
  input logic [SEG_BITS-1:0] cseg_wdata,
  input logic                oseg_we,
  input logic [SEG_BITS-1:0] oseg_wdata,
  input logic [SEG_BITS-1:0] cseg_q,
  input logic [SEG_BITS-1:0] oseg_q,
  input logic [PA_W-1:0]     paddr,
  input logic                ref_err,
  input logic                win_oper
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (cseg_q == '0 && oseg_q == '0));

  p_code_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cseg_we |=> cseg_q == $past(cseg_wdata));

  p_oper_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oseg_we |=> oseg_q == $past(oseg_wdata));

  p_code_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !laddr[LA_W-1] |-> paddr[PA_W-1:OFS_BITS] == cseg_q);

  p_oper_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_oper |-> paddr[PA_W-1:OFS_BITS] == oseg_q);

  p_offset_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    paddr[OFS_BITS-1:0] == laddr[OFS_BITS-1:0]);

  p_err_needs_oper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_err |-> (laddr[LA_W-1] && acc_kind == 2'b01));

  p_no_err_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind != 2'b01) |-> !ref_err);

  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cseg_we |=> $stable(cseg_q));

  p_oper_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !oseg_we |=> $stable(oseg_q));
endmodule

bind seg_xlate segx_checker #(.SEG_BITS(SEG_BITS), .OFS_BITS(OFS_BITS)) u_segx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .laddr      (laddr),
  .acc_kind   (acc_kind),
  .cseg_we    (cseg_we),
  .cseg_wdata (cseg_wdata),
  .oseg_we    (oseg_we),
  .oseg_wdata (oseg_wdata),
  .cseg_q     (cseg_q),
  .oseg_q     (oseg_q),
  .paddr      (paddr),
  .ref_err    (ref_err),
  .win_oper   (win_oper)
);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] laddr;
  logic [1:0]  acc_kind;
  logic        cseg_we, oseg_we;
  logic [4:0]  cseg_wdata, oseg_wdata;
  logic [4:0]  cseg_q, oseg_q;
  logic [14:0] paddr;
  logic        ref_err;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst_n(rst_n), .laddr(laddr), .acc_kind(acc_kind),
    .cseg_we(cseg_we), .cseg_wdata(cseg_wdata),
    .oseg_we(oseg_we), .oseg_wdata(oseg_wdata),
    .cseg_q(cseg_q), .oseg_q(oseg_q), .paddr(paddr), .ref_err(ref_err)
  );

  // Bench model: segment number times segment size plus offset.
  function automatic int expect_pa(int cs, int os, int la);
    int seg;
    seg = (la >= 1024) ? os : cs;
    return seg * 1024 + (la % 1024);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic load(logic wc, int vc, logic wo, int vo);
    @(negedge clk);
    cseg_we = wc; cseg_wdata = 5'(vc);
    oseg_we = wo; oseg_wdata = 5'(vo);
    @(negedge clk);
    cseg_we = 1'b0; oseg_we = 1'b0;
    #1;
  endtask

  task automatic probe(string req, int la, int kind, int cs, int os, int exp_err);
    laddr = 11'(la); acc_kind = 2'(kind);
    #1;
    chk(req, int'(paddr), expect_pa(cs, os, la));
    chk(req, int'(ref_err), exp_err);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    settle();
    rst_n = 1'b1;
    settle();
    chk("R1 cseg", int'(cseg_q), 0);
    chk("R1 oseg", int'(oseg_q), 0);
    probe("R1 paddr", 11'o1234, 2, 0, 0, 0);
  endtask

  task automatic t_code_load();
    load(1'b1, 5'o23, 1'b0, 0);
    chk("R2 cseg", int'(cseg_q), 8'o23);
    chk("R2 oseg kept", int'(oseg_q), 0);
    probe("R4 low window", 11'o0777, 0, 8'o23, 0, 0);
    probe("R4 low top", 11'o1777, 1, 8'o23, 0, 0);
  endtask

  task automatic t_oper_load();
    load(1'b0, 0, 1'b1, 5'o05);
    chk("R3 oseg", int'(oseg_q), 5);
    chk("R3 cseg kept", int'(cseg_q), 8'o23);
    probe("R5 high window", 11'o2000, 2, 8'o23, 5, 0);
    probe("R5 high top", 11'o3777, 0, 8'o23, 5, 0);
  endtask

  task automatic t_err();
    probe("R6 direct high", 11'o2345, 1, 8'o23, 5, 1);
    probe("R7 direct low", 11'o0345, 1, 8'o23, 5, 0);
    probe("R7 fetch high", 11'o2345, 0, 8'o23, 5, 0);
    probe("R7 indirect high", 11'o2345, 2, 8'o23, 5, 0);
    probe("R7 reserved high", 11'o2345, 3, 8'o23, 5, 0);
  endtask

  task automatic t_placement();
    load(1'b1, 7, 1'b1, 7);
    probe("R8 equal low", 11'o0012, 0, 7, 7, 0);
    probe("R8 equal high", 11'o2012, 2, 7, 7, 0);
    load(1'b1, 31, 1'b1, 0);
    probe("R8 code above low", 11'o1000, 0, 31, 0, 0);
    probe("R8 code above high", 11'o3000, 2, 31, 0, 0);
    load(1'b1, 4, 1'b1, 5);
    probe("R8 adjacent low", 11'o1777, 0, 4, 5, 0);
    probe("R8 adjacent high", 11'o2000, 2, 4, 5, 0);
  endtask

  task automatic t_ignored();
    @(negedge clk);
    cseg_wdata = 5'd19; oseg_wdata = 5'd26;
    laddr = 11'o0100; acc_kind = 2'b00;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 cseg", int'(cseg_q), 4);
    chk("R9 oseg", int'(oseg_q), 5);
    probe("R9 paddr low", 11'o0100, 0, 4, 5, 0);
    probe("R9 paddr high", 11'o2100, 2, 4, 5, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cseg_we = 1'b1; cseg_wdata = 5'd12;
    laddr = 11'o0200; acc_kind = 2'b00;
    #1;
    chk("R10 before edge", int'(paddr), expect_pa(4, 5, 11'o0200));
    @(negedge clk);
    cseg_we = 1'b0;
    #1;
    chk("R10 after edge", int'(paddr), expect_pa(12, 5, 11'o0200));
    @(negedge clk);
    oseg_we = 1'b1; oseg_wdata = 5'd30;
    laddr = 11'o2200; acc_kind = 2'b10;
    #1;
    chk("R10 oper before", int'(paddr), expect_pa(12, 5, 11'o2200));
    @(negedge clk);
    oseg_we = 1'b0;
    #1;
    chk("R10 oper after", int'(paddr), expect_pa(12, 30, 11'o2200));
  endtask

  initial begin
    rst_n = 1'b0; laddr = '0; acc_kind = '0;
    cseg_we = 1'b0; oseg_we = 1'b0; cseg_wdata = '0; oseg_wdata = '0;
    t_reset();
    t_code_load();
    t_oper_load();
    t_err();
    t_placement();
    t_ignored();
    t_same_cycle();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule